// File: doc/BRIEF.md
# Panel logic power sequencer

This block brings the logic supply of a display module up and down in a fixed order and controls when video data and control may be sent on the serial link. It has two outputs. One enables the supply regulator. The other gates the link transmitter. Two comparator inputs report the supply level: one is high when the supply is above 10% of nominal, the other when it is above 90%. A timebase pulse paces all timing. The parameter `TICKS_PER_MS` sets how many of these pulses make one millisecond. The default is 2, so one tick is 0.5 ms.

On a power-up request, the block enables the supply and times the ramp from the 10% crossing to the 90% crossing. A ramp that is too fast or too slow causes a trip. After a good ramp, the block waits a programmed delay and then enables the link. On a power-down request, it disables the link, waits a programmed delay and then cuts the supply. Once the supply falls below 10%, the block enforces a rest interval before another power-up can begin. A loss of the supply while it is enabled also causes a trip. A trip cuts both outputs and stays in place until software clears it, and the clear is accepted only after the rest interval has run with the supply off. The comparator inputs are assumed to be already synchronous to `clk`.

Top module: `panel_pwr_seq`

## Requirements
- R1: After reset, `state_o` is 0 (idle), both enables are low, both rise flags are low and `rise_ticks_o` is 0.
- R2: A request on `up_req_i` in idle moves the block to state 1 (ramp). `sup_en_o` is high on the next clock while `link_en_o` stays low.
- R3: In state 1, ticks are counted while `vdd_lo_i` is high and `vdd_hi_i` is low. The outcome depends on the count when `vdd_hi_i` rises:
  - If the count is below `RISE_MIN_T` (1), the block trips (state 7) with `fast_o` set.
  - If a tick would take the count past `RISE_MAX_T` (20), the block trips with `slow_o` set.
  - Otherwise the block enters state 2 (settle), and `rise_ticks_o` holds the count.
- R4: In state 2, `link_en_o` rises (state 3, live) one clock after min(`on_dly_ms_i`, 50) × `TICKS_PER_MS` ticks. A value of zero enables the link on the next clock.
- R5: `dn_req_i` in state 3 drops `link_en_o` on the next clock (state 4, drain). `sup_en_o` drops (state 5, fall) one clock after min(`off_dly_ms_i`, 50) × `TICKS_PER_MS` ticks.
- R6: When `vdd_lo_i` falls in state 5, the block enters state 6 (rest) and stays there for `HOLDOFF_MS` × `TICKS_PER_MS` (1000) ticks. It then goes to idle. If `up_req_i` arrived during the rest, it goes straight to state 1 instead.
- R7: If `vdd_hi_i` is low in state 2, 3 or 4, the block enters state 7 on the next clock with both enables low.
- R8: State 7 is left for idle only when `clr_i` is high and at least 1000 ticks have been counted with `vdd_lo_i` low. Any high `vdd_lo_i` restarts that count. An earlier `clr_i` leaves the block in state 7. Leaving the trip clears both rise flags.
- R9: A delay input above 50 ms acts as exactly 50 ms.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Timebase pulse, one clock wide |
| up_req_i | input | 1 | Power-up request pulse |
| dn_req_i | input | 1 | Power-down request pulse |
| clr_i | input | 1 | Trip clear |
| vdd_hi_i | input | 1 | Supply above 90% of nominal |
| vdd_lo_i | input | 1 | Supply above 10% of nominal |
| on_dly_ms_i | input | DLY_W (7) | Delay from a good ramp to link enable, in ms |
| off_dly_ms_i | input | DLY_W (7) | Delay from link disable to supply cut, in ms |
| sup_en_o | output | 1 | Supply regulator enable |
| link_en_o | output | 1 | Link transmitter enable |
| state_o | output | 3 | Current state code (0 to 7) |
| fast_o | output | 1 | Ramp-too-fast flag |
| slow_o | output | 1 | Ramp-too-slow flag |
| rise_ticks_o | output | CNT_W (10) | Measured rise time in ticks |

## Verification
A wrong state shows at the ports one clock after it is entered: the enable pair and `state_o` are decoded directly from the state register. A miscounted interval shows as an edge of `sup_en_o` or `link_en_o` that is off by one or more ticks. The bench therefore samples each edge one tick before and one tick after the expected point. A broken trip exit is seen only when `clr_i` is applied, so the clear is tried once before the rest interval has run, and once after.

// File: rtl/pseq_pkg.sv
`timescale 1ns/1ps
// Shared types for the panel power sequencer.
// The state codes are visible at the top-level status port.
package pseq_pkg;
    typedef enum logic [2:0] {
        PS_IDLE   = 3'd0,
        PS_RISE   = 3'd1,
        PS_SETTLE = 3'd2,
        PS_LIVE   = 3'd3,
        PS_DRAIN  = 3'd4,
        PS_FALL   = 3'd5,
        PS_REST   = 3'd6,
        PS_TRIP   = 3'd7
    } pseq_state_e;
endpackage

// File: rtl/pseq_timer.sv
`timescale 1ns/1ps
// Interval counter shared by all timed phases.
// Counts enabled ticks and saturates at all ones.
// Assumes the clear input takes priority over the increment.
module pseq_timer #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] cnt_o
);
    // Clear, or advance by one unless saturated.
    always_ff @(posedge clk) begin
        if (!rst_n)                        cnt_o <= '0;
        else if (clr_i)                    cnt_o <= '0;
        else if (inc_i && (cnt_o != '1))   cnt_o <= cnt_o + 1'b1;
    end
endmodule

// File: rtl/pseq_dly_clamp.sv
`timescale 1ns/1ps
// Converts a delay in milliseconds into ticks.
// The delay is limited to MAX_MS first.
// Assumes MAX_MS * TPM fits in CNT_W bits.
module pseq_dly_clamp #(
    parameter int DLY_W  = 7,
    parameter int MAX_MS = 50,
    parameter int TPM    = 2,
    parameter int CNT_W  = 10
) (
    input  logic [DLY_W-1:0] ms_i,
    output logic [CNT_W-1:0] ticks_o
);
    localparam logic [DLY_W-1:0] MAX_C = DLY_W'(MAX_MS);
    localparam logic [CNT_W-1:0] TPM_C = CNT_W'(TPM);

    logic [DLY_W-1:0] lim;

    // Limit the value, then scale it to ticks.
    always_comb begin
        lim     = (ms_i > MAX_C) ? MAX_C : ms_i;
        ticks_o = CNT_W'(lim) * TPM_C;
    end
endmodule

// File: rtl/pseq_fsm.sv
`timescale 1ns/1ps
// Sequencing state machine.
// It decides every transition from the comparator levels and the shared
// counter value. It also drives the counter's clear and increment, the
// rise-time capture and the two rise flags.
// Assumes the comparator inputs are synchronous to clk.
module pseq_fsm
    import pseq_pkg::*;
#(
    parameter int CNT_W      = 10,
    parameter int RISE_MIN_T = 1,
    parameter int RISE_MAX_T = 20,
    parameter int HOLD_T     = 1000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             up_i,
    input  logic             dn_i,
    input  logic             clr_i,
    input  logic             hi_i,
    input  logic             lo_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] on_t_i,
    input  logic [CNT_W-1:0] off_t_i,
    output pseq_state_e      st_o,
    output logic             tmr_clr_o,
    output logic             tmr_inc_o,
    output logic             fast_o,
    output logic             slow_o,
    output logic [CNT_W-1:0] rise_o
);
    localparam logic [CNT_W-1:0] MIN_C  = CNT_W'(RISE_MIN_T);
    localparam logic [CNT_W-1:0] MAX_C  = CNT_W'(RISE_MAX_T);
    localparam logic [CNT_W-1:0] HOLD_C = CNT_W'(HOLD_T);

    pseq_state_e st_q, st_d;
    logic        pend_q;

    // Next-state decision.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            PS_IDLE:   if (up_i) st_d = PS_RISE;
            PS_RISE: begin
                if (hi_i)
                    st_d = (cnt_i < MIN_C) ? PS_TRIP : PS_SETTLE;
                else if (tick_i && lo_i && (cnt_i == MAX_C))
                    st_d = PS_TRIP;
            end
            PS_SETTLE: begin
                if (!hi_i)                  st_d = PS_TRIP;
                else if (cnt_i >= on_t_i)   st_d = PS_LIVE;
            end
            PS_LIVE: begin
                if (!hi_i)                  st_d = PS_TRIP;
                else if (dn_i)              st_d = PS_DRAIN;
            end
            PS_DRAIN: begin
                if (!hi_i)                  st_d = PS_TRIP;
                else if (cnt_i >= off_t_i)  st_d = PS_FALL;
            end
            PS_FALL:   if (!lo_i) st_d = PS_REST;
            PS_REST:   if (cnt_i >= HOLD_C) st_d = (pend_q || up_i) ? PS_RISE : PS_IDLE;
            PS_TRIP:   if (clr_i && (cnt_i >= HOLD_C)) st_d = PS_IDLE;
            default:   st_d = PS_TRIP;
        endcase
    end

    // Counter control.
    // Cleared on any state change, and in a trip while the supply is up.
    // In the ramp it counts only between the two thresholds.
    always_comb begin
        tmr_clr_o = (st_d != st_q) || ((st_q == PS_TRIP) && lo_i);
        if (st_q == PS_RISE)      tmr_inc_o = tick_i && lo_i && !hi_i;
        else if (st_q == PS_TRIP) tmr_inc_o = tick_i && !lo_i;
        else                      tmr_inc_o = tick_i;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= PS_IDLE;
        else        st_q <= st_d;
    end

    // Remember a power-up request made during the rest interval.
    always_ff @(posedge clk) begin
        if (!rst_n || (st_q != PS_REST)) pend_q <= 1'b0;
        else if (up_i)                   pend_q <= 1'b1;
    end

    // Rise flags: set on a ramp trip, cleared when the trip is cleared.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fast_o <= 1'b0;
            slow_o <= 1'b0;
        end else if ((st_q == PS_RISE) && (st_d == PS_TRIP)) begin
            fast_o <= hi_i;
            slow_o <= !hi_i;
        end else if ((st_q == PS_TRIP) && (st_d == PS_IDLE)) begin
            fast_o <= 1'b0;
            slow_o <= 1'b0;
        end
    end

    // Capture the measured rise time at the 90% crossing.
    always_ff @(posedge clk) begin
        if (!rst_n)                       rise_o <= '0;
        else if ((st_q == PS_RISE) && hi_i) rise_o <= cnt_i;
    end

    assign st_o = st_q;

    // R2
    rise_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == PS_RISE) && ($past(st_q) != PS_RISE)) |-> ($past(up_i) || $past(pend_q)));
    // R3
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fast_o, slow_o}));
    // R4
    link_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == PS_LIVE) && ($past(st_q) == PS_SETTLE)) |-> ($past(cnt_i) >= $past(on_t_i)));
    // R7
    drop_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((($past(st_q) == PS_SETTLE) || ($past(st_q) == PS_LIVE) || ($past(st_q) == PS_DRAIN))
         && !$past(hi_i)) |-> (st_q == PS_TRIP));
    // R8
    trip_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(st_q) == PS_TRIP) && (st_q != PS_TRIP)) |-> $past(clr_i));
endmodule

// File: rtl/panel_pwr_seq.sv
`timescale 1ns/1ps
// Top level of the panel logic power sequencer.
// Connects the delay clamps, the shared interval counter and the state
// machine, and decodes the two enables from the state.
// Assumes tick_i pulses are one clock wide.
module panel_pwr_seq
    import pseq_pkg::*;
#(
    parameter int TICKS_PER_MS = 2,
    parameter int RISE_MIN_T   = 1,
    parameter int RISE_MAX_T   = 20,
    parameter int HOLDOFF_MS   = 500,
    parameter int DLY_MAX_MS   = 50,
    parameter int DLY_W        = 7,
    localparam int HOLD_T      = HOLDOFF_MS * TICKS_PER_MS,
    localparam int CNT_W       = $clog2(HOLD_T + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             up_req_i,
    input  logic             dn_req_i,
    input  logic             clr_i,
    input  logic             vdd_hi_i,
    input  logic             vdd_lo_i,
    input  logic [DLY_W-1:0] on_dly_ms_i,
    input  logic [DLY_W-1:0] off_dly_ms_i,
    output logic             sup_en_o,
    output logic             link_en_o,
    output logic [2:0]       state_o,
    output logic             fast_o,
    output logic             slow_o,
    output logic [CNT_W-1:0] rise_ticks_o
);
    localparam int NDLY = 2;

    logic [DLY_W-1:0] dly_ms [NDLY];
    logic [CNT_W-1:0] dly_t  [NDLY];
    logic [CNT_W-1:0] cnt;
    logic             tmr_clr, tmr_inc;
    pseq_state_e      st;

    assign dly_ms[0] = on_dly_ms_i;
    assign dly_ms[1] = off_dly_ms_i;

    for (genvar g = 0; g < NDLY; g++) begin : g_clamp
        pseq_dly_clamp #(
            .DLY_W (DLY_W),
            .MAX_MS(DLY_MAX_MS),
            .TPM   (TICKS_PER_MS),
            .CNT_W (CNT_W)
        ) u_clamp (
            .ms_i   (dly_ms[g]),
            .ticks_o(dly_t[g])
        );
    end

    pseq_timer #(.CNT_W(CNT_W)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .clr_i(tmr_clr),
        .inc_i(tmr_inc),
        .cnt_o(cnt)
    );

    pseq_fsm #(
        .CNT_W     (CNT_W),
        .RISE_MIN_T(RISE_MIN_T),
        .RISE_MAX_T(RISE_MAX_T),
        .HOLD_T    (HOLD_T)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick_i),
        .up_i     (up_req_i),
        .dn_i     (dn_req_i),
        .clr_i    (clr_i),
        .hi_i     (vdd_hi_i),
        .lo_i     (vdd_lo_i),
        .cnt_i    (cnt),
        .on_t_i   (dly_t[0]),
        .off_t_i  (dly_t[1]),
        .st_o     (st),
        .tmr_clr_o(tmr_clr),
        .tmr_inc_o(tmr_inc),
        .fast_o   (fast_o),
        .slow_o   (slow_o),
        .rise_o   (rise_ticks_o)
    );

    // Decode the enables and the status code from the state.
    always_comb begin
        sup_en_o  = (st == PS_RISE) || (st == PS_SETTLE) || (st == PS_LIVE) || (st == PS_DRAIN);
        link_en_o = (st == PS_LIVE);
        state_o   = st;
    end

    // R4
    link_good_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_en_o) |-> $past(vdd_hi_i));
    // R5
    supply_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sup_en_o) && (state_o != 3'd7)) |-> !$past(link_en_o));
endmodule

// File: tb/panel_pwr_seq_tb.sv
`timescale 1ns/1ps
// Self-checking bench for panel_pwr_seq.
// Drives the supply comparators as a tick-paced ramp model.
module panel_pwr_seq_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0, up = 1'b0, dn = 1'b0, clr = 1'b0;
    logic       hi = 1'b0, lo = 1'b0;
    logic [6:0] on_ms = '0, off_ms = '0;
    logic       sup_en, link_en, fast, slow;
    logic [2:0] state;
    logic [9:0] rise_t;
    int nchk = 0, nerr = 0;

    always #2.5 clk = ~clk;

    panel_pwr_seq u_dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .up_req_i(up), .dn_req_i(dn),
        .clr_i(clr), .vdd_hi_i(hi), .vdd_lo_i(lo), .on_dly_ms_i(on_ms),
        .off_dly_ms_i(off_ms), .sup_en_o(sup_en), .link_en_o(link_en),
        .state_o(state), .fast_o(fast), .slow_o(slow), .rise_ticks_o(rise_t)
    );

    // Ramp table: ticks between the 10% and 90% crossings, and expected results.
    localparam int NV = 5;
    localparam int RISE_N [NV] = '{0, 1, 7, 20, 21};
    localparam int EXP_ST [NV] = '{7, 2, 2, 2, 7};
    localparam int EXP_FA [NV] = '{1, 0, 0, 0, 0};
    localparam int EXP_SL [NV] = '{0, 0, 0, 0, 1};

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tk(input int n);
        repeat (n) begin
            tick = 1'b1; @(negedge clk);
            tick = 1'b0; @(negedge clk);
        end
    endtask

    task automatic pulse_up();
        up = 1'b1; @(negedge clk); up = 1'b0;
    endtask

    task automatic pulse_dn();
        dn = 1'b1; @(negedge clk); dn = 1'b0;
    endtask

    task automatic pulse_clr();
        clr = 1'b1; @(negedge clk); clr = 1'b0;
    endtask

    // Supply ramp model: n ticks from the 10% to the 90% crossing.
    // With n above 20 the 90% crossing never arrives.
    task automatic ramp_up(input int n);
        pulse_up();
        lo = 1'b1;
        tk((n > 20) ? 21 : n);
        if (n <= 20) begin
            hi = 1'b1;
            cyc(1);
        end
    endtask

    // Normal power-down from the live state with zero off delay.
    task automatic power_down();
        pulse_dn();
        cyc(1);
        hi = 1'b0; lo = 1'b0;
        cyc(1);
        tk(1000);
        cyc(1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        cyc(4);
        chk("R1 state", state, 0);
        chk("R1 sup_en", sup_en, 0);
        chk("R1 link_en", link_en, 0);
        chk("R1 flags", {fast, slow}, 0);
        chk("R1 rise", rise_t, 0);
        rst_n = 1'b1;
        cyc(2);

        // Table walk over ramp times.
        for (int i = 0; i < NV; i++) begin
            on_ms = '0; off_ms = '0;
            ramp_up(RISE_N[i]);
            chk("R3 state", state, EXP_ST[i]);
            chk("R3 fast flag", fast, EXP_FA[i]);
            chk("R3 slow flag", slow, EXP_SL[i]);
            if (EXP_ST[i] == 2) begin
                chk("R3 rise ticks", rise_t, RISE_N[i]);
                cyc(1);
                chk("R4 zero delay link", link_en, 1);
                power_down();
                chk("R6 back to idle", state, 0);
            end else begin
                chk("R7 trip cuts supply", sup_en, 0);
                hi = 1'b0; lo = 1'b0;
                cyc(1);
                tk(1000);
                pulse_clr();
                chk("R8 trip cleared", state, 0);
                chk("R8 flags cleared", {fast, slow}, 0);
            end
        end

        // R2: power-up request.
        on_ms = 7'd3; off_ms = 7'd2;
        pulse_up();
        chk("R2 state", state, 1);
        chk("R2 sup_en", sup_en, 1);
        chk("R2 link_en", link_en, 0);

        // R4: 3 ms on delay, which is 6 ticks.
        lo = 1'b1; tk(4); hi = 1'b1; cyc(1);
        chk("R4 settle", state, 2);
        tk(5); cyc(1);
        chk("R4 link low before delay", link_en, 0);
        tk(1); cyc(1);
        chk("R4 link high at delay", link_en, 1);

        // R5: 2 ms off delay, which is 4 ticks.
        pulse_dn();
        chk("R5 drain state", state, 4);
        chk("R5 link dropped", link_en, 0);
        tk(3); cyc(1);
        chk("R5 supply held", sup_en, 1);
        tk(1); cyc(1);
        chk("R5 supply cut", sup_en, 0);
        chk("R5 fall state", state, 5);

        // R6: rest interval with a pending power-up request.
        hi = 1'b0; cyc(1);
        chk("R6 waits for 10% fall", state, 5);
        lo = 1'b0; cyc(1);
        chk("R6 rest", state, 6);
        tk(10); pulse_up();
        chk("R6 request deferred", state, 6);
        tk(989); cyc(1);
        chk("R6 still resting", state, 6);
        tk(1); cyc(1);
        chk("R6 pending served", state, 1);
        chk("R6 supply on", sup_en, 1);

        // R9: 90 ms is clamped to 50 ms, which is 100 ticks.
        on_ms = 7'd90;
        lo = 1'b1; tk(3); hi = 1'b1; cyc(1);
        tk(99); cyc(1);
        chk("R9 link low before clamp", link_en, 0);
        tk(1); cyc(1);
        chk("R9 link at clamp", link_en, 1);

        // R7: brownout while live.
        hi = 1'b0; cyc(1);
        chk("R7 trip", state, 7);
        chk("R7 supply off", sup_en, 0);
        chk("R7 link off", link_en, 0);

        // R8: the clear is accepted only after 1000 ticks with the supply off.
        tk(1200); pulse_clr();
        chk("R8 clear while supply up", state, 7);
        lo = 1'b0;
        tk(500); pulse_clr();
        chk("R8 early clear ignored", state, 7);
        tk(500); pulse_clr();
        chk("R8 clear accepted", state, 0);

        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end
endmodule